// File: doc/BRIEF.md
# Logic Unit with Barrel Shifter

This block is the datapath core of a microprogrammed processor's logic unit. Two 32-bit operands enter together with a 4-bit function code. The code selects one of sixteen functions: six arithmetic ones that add a modified Y to X, and ten bitwise ones. A carry-inhibit control splits every addition into four independent 8-bit lanes, so a single operation can work on packed bytes. The function result is passed to a barrel shifter. The shifter can pass the value through, shift it right, shift it left, or rotate it. A 5-bit shift amount controls the shift.

The unfiltered function result and the shifted result both leave the block, because downstream destination logic may merge the two. Four condition flags describe the function result: top bit, bottom bit, all ones, and overflow. They are captured on a clock edge only when the logic-unit step input is high, and they hold their values between steps. Selecting operands and writing destination registers are the job of the surrounding logic.

Top module: `logic_shift_unit`

## Requirements
- R1: The bitwise function codes give: 1 ~(X|Y), 2 ~X&Y, 4 ~(X&Y), 6 X^Y, 7 X&~Y, 8 ~X|Y, 9 (X&Y)|~(X|Y), 11 X&Y, 13 X|~Y, 14 X|Y, on `adder_out`.
- R2: The arithmetic codes add X to a modified Y: 0 Y, 3 Y+1, 5 X|Y, 10 X&Y, 12 ~Y (giving X-Y-1), 15 -Y (giving X-Y). Results wrap modulo 2^32.
- R3: When `carry_inhibit` is 1, an arithmetic code sums each byte lane (bits 7:0, 15:8, 23:16, 31:24) separately modulo 256. The Y modification is applied to the full 32-bit Y first.
- R4: The overflow flag takes the carry out of bit 31 of the sum. With inhibit set, that is the carry out of the top byte lane. For bitwise codes the flag is 0.
- R5: The flag `flag_msb` takes bit 31 of the function result, `flag_lsb` takes bit 0, and `flag_ones` is 1 exactly when the result is 0xFFFFFFFF.
- R6: All four flags are 0 after reset. They load on a rising clock edge where `step` is 1 and keep their values on edges where `step` is 0.
- R7: `shift_sel` 0 passes the function result to `shift_out`. `shift_sel` 1 shifts it right logically by `shift_amt`.
- R8: `shift_sel` 2 shifts the result left by 32 minus `shift_amt`. When `shift_amt` is 0 this gives zero.
- R9: `shift_sel` 3 rotates the result right by `shift_amt`. When `shift_amt` is 0 the output equals the function result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| step | input | 1 | Logic-unit cycle strobe; loads the flags |
| x_in | input | 32 | X operand |
| y_in | input | 32 | Y operand |
| op | input | 4 | Function code |
| carry_inhibit | input | 1 | Split additions into byte lanes |
| shift_sel | input | 2 | Shifter mode: pass, right, left, rotate |
| shift_amt | input | 5 | Shift amount |
| adder_out | output | 32 | Unshifted function result |
| shift_out | output | 32 | Shifter result |
| flag_msb | output | 1 | Registered result bit 31 |
| flag_lsb | output | 1 | Registered result bit 0 |
| flag_ones | output | 1 | Registered all-ones indicator |
| flag_ovf | output | 1 | Registered overflow (carry out of bit 31) |

## Verification
The hardest case to reach is a carry that crosses a byte boundary while carry inhibit is set. With inhibit on, the carry must be dropped inside the word but must still appear as overflow when it leaves the top lane. The stimulus uses operands with every byte at 0xFF or 0x80 and adds 1 or 0x80 in each lane, once with inhibit and once without. It then runs every function code over these operand patterns. Shift amount 0 is paired with the left and rotate modes to reach the 32-position edge. The driver also applies steps with `step` low and fresh operands, so that a flag that changes when it should hold gets caught.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_NOR      = 4'd1,
    OP_NXANDY   = 4'd2,
    OP_ADDINC   = 4'd3,
    OP_NAND     = 4'd4,
    OP_ADDOR    = 4'd5,
    OP_XOR      = 4'd6,
    OP_XANDNY   = 4'd7,
    OP_NXORY    = 4'd8,
    OP_EQV      = 4'd9,
    OP_ADDAND   = 4'd10,
    OP_AND      = 4'd11,
    OP_SUBDEC   = 4'd12,
    OP_XORNY    = 4'd13,
    OP_OR       = 4'd14,
    OP_SUB      = 4'd15
  } lu_op_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_ROT   = 2'd3
  } sh_sel_e;

  // Arithmetic class: codes that route through the adder.
  function automatic logic op_is_arith(input logic [3:0] code);
    case (code)
      OP_ADD, OP_ADDINC, OP_ADDOR, OP_ADDAND, OP_SUBDEC, OP_SUB: op_is_arith = 1'b1;
      default: op_is_arith = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lsu_adder.sv
`timescale 1ns/1ps
module lsu_adder
  import lsu_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANE_W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [3:0]   op,
  input  logic         inhibit,
  output logic [W-1:0] result,
  output logic [W-1:0] carry_vec,
  output logic         arith,
  output logic         ovf
);
  localparam int NLANE = W / LANE_W;

  // Y-side modification done before summation (R2)
  function automatic logic [W-1:0] y_adjust(input logic [3:0] code,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    case (code)
      OP_ADDINC: y_adjust = b + 1'b1;
      OP_ADDOR:  y_adjust = a | b;
      OP_ADDAND: y_adjust = a & b;
      OP_SUBDEC: y_adjust = ~b;
      OP_SUB:    y_adjust = ~b + 1'b1;
      default:   y_adjust = b;
    endcase
  endfunction

  // Bitwise functions (R1)
  function automatic logic [W-1:0] bitwise(input logic [3:0] code,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (code)
      OP_NOR:    bitwise = ~(a | b);
      OP_NXANDY: bitwise = ~a & b;
      OP_NAND:   bitwise = ~(a & b);
      OP_XOR:    bitwise = a ^ b;
      OP_XANDNY: bitwise = a & ~b;
      OP_NXORY:  bitwise = ~a | b;
      OP_EQV:    bitwise = (a & b) | ~(a | b);
      OP_AND:    bitwise = a & b;
      OP_XORNY:  bitwise = a | ~b;
      OP_OR:     bitwise = a | b;
      default:   bitwise = '0;
    endcase
  endfunction

  function automatic logic [W-1:0] majority(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic [W-1:0] c);
    majority = (a & b) | (b & c) | (a & c);
  endfunction

  logic [W-1:0] y_mod;
  logic [W-1:0] sum_full;
  logic [W-1:0] sum_lane;
  logic [W-1:0] sum_sel;
  logic [W-1:0] cout_vec;

  assign y_mod    = y_adjust(op, x, y);
  assign sum_full = x + y_mod;

  // Independent byte lanes for carry inhibit (R3)
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign sum_lane[g*LANE_W +: LANE_W] = x[g*LANE_W +: LANE_W] + y_mod[g*LANE_W +: LANE_W];
  end

  assign sum_sel   = inhibit ? sum_lane : sum_full;
  assign arith     = op_is_arith(op);
  assign result    = arith ? sum_sel : bitwise(op, x, y);
  // Carry recovery; zero for bitwise codes (R4)
  assign carry_vec = arith ? (x ^ y_mod ^ sum_sel) : '0;
  assign cout_vec  = arith ? majority(x, y_mod, carry_vec) : '0;
  assign ovf       = cout_vec[W-1];
endmodule

// File: rtl/lsu_shifter.sv
`timescale 1ns/1ps
module lsu_shifter
  import lsu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         din,
  input  logic [1:0]           sel,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         dout
);
  localparam int SW = $clog2(W);

  logic [SW:0]  left_amt;
  logic [W-1:0] right_val;
  logic [W-1:0] left_val;

  // Left distance reaches W when amt is 0, giving zero (R8)
  assign left_amt  = (SW+1)'(W) - {1'b0, amt};
  assign right_val = din >> amt;
  assign left_val  = din << left_amt;

  always_comb begin
    case (sel)
      SH_PASS:  dout = din;
      SH_RIGHT: dout = right_val;
      SH_LEFT:  dout = left_val;
      default:  dout = right_val ^ left_val;  // rotate right (R9)
    endcase
  end
endmodule

// File: rtl/lsu_flags.sv
`timescale 1ns/1ps
module lsu_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] result,
  input  logic         ovf_in,
  output logic         msb,
  output logic         lsb,
  output logic         ones,
  output logic         ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb  <= 1'b0;
      lsb  <= 1'b0;
      ones <= 1'b0;
      ovf  <= 1'b0;
    end else if (load) begin
      msb  <= result[W-1];
      lsb  <= result[0];
      ones <= &result;
      ovf  <= ovf_in;
    end
  end
endmodule

// File: rtl/logic_shift_unit.sv
`timescale 1ns/1ps
module logic_shift_unit
  import lsu_pkg::*;
#(
  parameter int W      = 32,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic [W-1:0]         x_in,
  input  logic [W-1:0]         y_in,
  input  logic [3:0]           op,
  input  logic                 carry_inhibit,
  input  logic [1:0]           shift_sel,
  input  logic [$clog2(W)-1:0] shift_amt,
  output logic [W-1:0]         adder_out,
  output logic [W-1:0]         shift_out,
  output logic                 flag_msb,
  output logic                 flag_lsb,
  output logic                 flag_ones,
  output logic                 flag_ovf
);
  logic [W-1:0] carry_vec;
  logic         is_arith;
  logic         ovf_now;
  logic         flag_load;

  assign flag_load = step;

  lsu_adder #(.W(W), .LANE_W(LANE_W)) u_adder (
    .x(x_in), .y(y_in), .op(op), .inhibit(carry_inhibit),
    .result(adder_out), .carry_vec(carry_vec), .arith(is_arith), .ovf(ovf_now)
  );

  lsu_shifter #(.W(W)) u_shifter (
    .din(adder_out), .sel(shift_sel), .amt(shift_amt), .dout(shift_out)
  );

  lsu_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .load(flag_load), .result(adder_out), .ovf_in(ovf_now),
    .msb(flag_msb), .lsb(flag_lsb), .ones(flag_ones), .ovf(flag_ovf)
  );
endmodule

// File: rtl/logic_shift_unit_chk.sv
`timescale 1ns/1ps
module logic_shift_unit_chk
  import lsu_pkg::*;
#(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 step,
  input logic [3:0]           op,
  input logic [1:0]           shift_sel,
  input logic [$clog2(W)-1:0] shift_amt,
  input logic [W-1:0]         adder_out,
  input logic [W-1:0]         shift_out,
  input logic                 flag_msb,
  input logic                 flag_lsb,
  input logic                 flag_ones,
  input logic                 flag_ovf
);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable({flag_msb, flag_lsb, flag_ones, flag_ovf}));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !op_is_arith(op)) |=> !flag_ovf);

  // R5
  msb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (flag_msb == $past(adder_out[W-1])) && (flag_lsb == $past(adder_out[0])));

  // R5
  ones_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (flag_ones == ($past(adder_out) == {W{1'b1}})));

  // R7
  pass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel == SH_PASS) |-> (shift_out == adder_out));

  // R9
  rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel == SH_ROT && shift_amt == '0) |-> (shift_out == adder_out));

  // R8
  left_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_sel == SH_LEFT && shift_amt == '0) |-> (shift_out == '0));
endmodule

bind logic_shift_unit logic_shift_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op(op), .shift_sel(shift_sel),
  .shift_amt(shift_amt), .adder_out(adder_out), .shift_out(shift_out),
  .flag_msb(flag_msb), .flag_lsb(flag_lsb), .flag_ones(flag_ones), .flag_ovf(flag_ovf)
);

// File: tb/logic_shift_unit_bench.sv
`timescale 1ns/1ps
module logic_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] x_in = '0;
  logic [31:0] y_in = '0;
  logic [3:0]  op = '0;
  logic        carry_inhibit = 1'b0;
  logic [1:0]  shift_sel = '0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] adder_out, shift_out;
  logic        flag_msb, flag_lsb, flag_ones, flag_ovf;

  always #4 clk = ~clk;  // 125 MHz

  logic_shift_unit u_logic_shift_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .x_in(x_in), .y_in(y_in), .op(op),
    .carry_inhibit(carry_inhibit), .shift_sel(shift_sel), .shift_amt(shift_amt),
    .adder_out(adder_out), .shift_out(shift_out), .flag_msb(flag_msb),
    .flag_lsb(flag_lsb), .flag_ones(flag_ones), .flag_ovf(flag_ovf)
  );

  typedef struct {
    int          rq;
    logic [31:0] add;
    logic [31:0] sh;
    logic [3:0]  fl;  // {msb, lsb, ones, ovf}
  } item_t;

  item_t       q[$];
  int          vectors = 0;
  int          miscompares = 0;
  logic [3:0]  exp_fl = 4'b0;
  bit          finished = 1'b0;

  // Reference model, written as a case on the code and a lane loop (R1 R2 R3 R4)
  task automatic model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic inh, output logic [31:0] r, output logic v);
    logic [31:0] yy;
    logic        ar;
    ar = 1'b1;
    yy = b;
    v  = 1'b0;
    r  = '0;
    case (c)
      4'd0:  yy = b;
      4'd3:  yy = b + 32'd1;
      4'd5:  yy = a | b;
      4'd10: yy = a & b;
      4'd12: yy = 32'hFFFF_FFFF - b;
      4'd15: yy = 32'd0 - b;
      default: ar = 1'b0;
    endcase
    if (ar) begin
      if (inh) begin
        for (int k = 0; k < 4; k++) begin
          logic [8:0] s;
          s = {1'b0, a[8*k +: 8]} + {1'b0, yy[8*k +: 8]};
          r[8*k +: 8] = s[7:0];
          if (k == 3) v = s[8];
        end
      end else begin
        logic [32:0] s33;
        s33 = {1'b0, a} + {1'b0, yy};
        r = s33[31:0];
        v = s33[32];
      end
    end else begin
      for (int i = 0; i < 32; i++) begin
        logic p, qb;
        p = a[i]; qb = b[i];
        case (c)
          4'd1:  r[i] = !(p || qb);
          4'd2:  r[i] = !p && qb;
          4'd4:  r[i] = !(p && qb);
          4'd6:  r[i] = p != qb;
          4'd7:  r[i] = p && !qb;
          4'd8:  r[i] = !p || qb;
          4'd9:  r[i] = p == qb;
          4'd11: r[i] = p && qb;
          4'd13: r[i] = p || !qb;
          default: r[i] = p || qb;
        endcase
      end
    end
  endtask

  // Shifter reference (R7 R8 R9)
  function automatic logic [31:0] shmodel(input logic [31:0] d, input logic [1:0] s,
                                          input logic [4:0] n);
    logic [63:0] dbl;
    dbl = {d, d} >> n;
    case (s)
      2'd0: shmodel = d;
      2'd1: shmodel = d >> n;
      2'd2: shmodel = (n == 0) ? 32'd0 : (d << (32 - n));
      default: shmodel = dbl[31:0];
    endcase
  endfunction

  // Driver: drive at negedge, push the expectation
  task automatic apply(input int rq, input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic inh, input logic [1:0] s,
                       input logic [4:0] n, input logic st);
    item_t it;
    logic [31:0] r;
    logic v;
    @(negedge clk);
    op = c; x_in = a; y_in = b; carry_inhibit = inh;
    shift_sel = s; shift_amt = n; step = st;
    model(c, a, b, inh, r, v);
    if (st) exp_fl = {r[31], r[0], (r == 32'hFFFF_FFFF), v};
    it.rq = rq; it.add = r; it.sh = shmodel(r, s, n); it.fl = exp_fl;
    q.push_back(it);
  endtask

  // Monitor: sample after the edge that registers the flags
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      bit bad;
      it = q.pop_front();
      bad = 1'b0;
      vectors++;
      if (adder_out !== it.add) begin
        $display("FAIL R%0d adder_out: got %h expected %h", it.rq, adder_out, it.add);
        bad = 1'b1;
      end
      if (shift_out !== it.sh) begin
        $display("FAIL R%0d shift_out: got %h expected %h", it.rq, shift_out, it.sh);
        bad = 1'b1;
      end
      if ({flag_msb, flag_lsb, flag_ones, flag_ovf} !== it.fl) begin
        $display("FAIL R%0d flags: got %b expected %b", it.rq,
                 {flag_msb, flag_lsb, flag_ones, flag_ovf}, it.fl);
        bad = 1'b1;
      end
      if (bad) miscompares++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: got timeout expected completion");
    miscompares++;
    finish_run();
  end

  initial begin
    logic [31:0] xs[4];
    logic [31:0] ys[4];
    xs[0] = 32'h1234_5678; ys[0] = 32'h0F0F_F0F0;
    xs[1] = 32'hFFFF_FFFF; ys[1] = 32'h0000_0001;
    xs[2] = 32'h80FF_7F01; ys[2] = 32'h8001_01FF;
    xs[3] = 32'h0000_0000; ys[3] = 32'hFFFF_FFFF;

    repeat (3) @(posedge clk);
    #1;
    // R6: reset state of flags
    vectors++;
    if ({flag_msb, flag_lsb, flag_ones, flag_ovf} !== 4'b0) begin
      $display("FAIL R6 reset flags: got %b expected 0000",
               {flag_msb, flag_lsb, flag_ones, flag_ovf});
      miscompares++;
    end
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: every code over several operand patterns, both carry modes
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int h = 0; h < 2; h++) begin
          apply(lsu_pkg::op_is_arith(4'(c)) ? (h ? 3 : 2) : 1,
                4'(c), xs[p], ys[p], h[0], 2'd0, 5'd0, 1'b1);
        end
      end
    end

    // R3 R4: carries across every byte boundary, with and without inhibit
    apply(3, 4'd0, 32'hFFFF_FFFF, 32'h0101_0101, 1'b1, 2'd0, 5'd0, 1'b1);
    apply(4, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 2'd0, 5'd0, 1'b1);
    apply(4, 4'd0, 32'h8080_8080, 32'h8080_8080, 1'b1, 2'd0, 5'd0, 1'b1);
    apply(4, 4'd0, 32'h00FF_FFFF, 32'h0000_0001, 1'b1, 2'd0, 5'd0, 1'b1);
    apply(2, 4'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 2'd0, 5'd0, 1'b1);
    apply(2, 4'd15, 32'h0000_0005, 32'h0000_0007, 1'b0, 2'd0, 5'd0, 1'b1);
    apply(2, 4'd12, 32'h0000_0005, 32'h0000_0005, 1'b0, 2'd0, 5'd0, 1'b1);

    // R5: all-ones from NOR of zeros
    apply(5, 4'd1, 32'h0, 32'h0, 1'b0, 2'd0, 5'd0, 1'b1);

    // R6: flags hold while step is low, under fresh operands
    apply(6, 4'd14, 32'h0000_0000, 32'h0000_0000, 1'b0, 2'd0, 5'd0, 1'b0);
    apply(6, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd1, 5'd3, 1'b0);

    // R7 R8 R9: shifter modes over several amounts
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 32; n += 5) begin
        apply(s == 0 ? 7 : (s == 1 ? 7 : (s == 2 ? 8 : 9)),
              4'd14, 32'hA5C3_0F81, 32'h0000_0000, 1'b0, 2'(s), 5'(n), 1'b1);
      end
      apply(s == 2 ? 8 : (s == 3 ? 9 : 7), 4'd14, 32'hDEAD_BEEF, 32'h0,
            1'b0, 2'(s), 5'd31, 1'b1);
    end
    // R8: left mode at amount 0 gives zero; R9: rotate at amount 0 passes
    apply(8, 4'd6, 32'hFFFF_0000, 32'h00FF_00FF, 1'b0, 2'd2, 5'd0, 1'b1);
    apply(9, 4'd6, 32'hFFFF_0000, 32'h00FF_00FF, 1'b0, 2'd3, 5'd0, 1'b1);

    @(negedge clk);
    step = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule